// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

A small circular reorder buffer for an out-of-order core's back end. The front end allocates one slot per decoded instruction in program order. Each slot holds the destination register, the PC and a flag that marks a branch. The slot index is handed back as the instruction's rename tag. Execution units later report completion by tag, together with a result, an exception flag and a mispredict flag. An accepted completion is echoed to waiting consumers as a wakeup carrying the tag. The result stays in the slot until the instruction commits.

The oldest slot retires once it has completed. A clean result is presented on the commit port, and only there does the architectural register file get written. When the oldest slot carries an exception, the buffer raises an exception request with that instruction's PC and drops every slot. A branch that completes as mispredicted discards all younger slots in the same cycle, and the tail moves back to just after the branch. Head and tail pointers each carry a wrap bit, so a full buffer and an empty one can be told apart.

Top module: `reorder_ring`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready`=1, `alloc_tag`=0, `commit_valid`=0 and `exc_valid`=0.
- R2: Each accepted allocation receives the next tag in sequence 0,1,…,DEPTH-1. With DEPTH slots occupied, `alloc_ready` is 0 and a request has no effect.
- R3: A completion for a live, not yet completed tag drives `wake_valid`=1 and `wake_tag`=that tag in the same cycle.
- R4: Commit is strictly in order, at most one per cycle. The oldest slot is presented on the commit port (`commit_tag`, `commit_dest`, `commit_data`) starting the cycle after its completion is accepted. Younger completed slots wait behind an incomplete older one.
- R5: A slot whose completion carries `cmp_exc`=1 is never committed. Once it is oldest, `exc_valid`=1 and `exc_pc`=its PC for one cycle, and the buffer is empty the cycle after. The next tag is then the faulting slot's index. While the faulting slot is still younger, nothing is signalled.
- R6: A completion with `cmp_mispred`=1 for a slot allocated with `alloc_branch`=1 drives `flush_valid`=1 and `flush_tag`=that tag in the same cycle, with `alloc_ready`=0 in that cycle. All younger slots are discarded. The next allocated tag is the branch tag plus one, modulo DEPTH. The branch itself still commits.
- R7: A completion for a tag that is not live, for example a flushed one, is ignored: there is no wakeup and no later commit.
- R8: `cmp_mispred` on a slot that was not allocated as a branch is ignored: there is no flush and no slot is discarded.
- R9: Tags wrap from DEPTH-1 back to 0. Full and empty stay correct across the wrap, including after a mispredict rewinds the tail across it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_dest | input | AREG_W | Destination architectural register |
| alloc_pc | input | PC_W | Instruction PC |
| alloc_branch | input | 1 | Instruction is a branch |
| alloc_ready | output | 1 | Allocation accepted this cycle if requested |
| alloc_tag | output | TAG_W | Tag given to the current allocation |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | TAG_W | Tag of completing instruction |
| cmp_data | input | DATA_W | Result value |
| cmp_exc | input | 1 | Instruction raised an exception |
| cmp_mispred | input | 1 | Branch was mispredicted |
| wake_valid | output | 1 | Wakeup broadcast valid |
| wake_tag | output | TAG_W | Tag broadcast to waiting consumers |
| flush_valid | output | 1 | Younger slots discarded after a mispredict |
| flush_tag | output | TAG_W | Tag of the mispredicted branch |
| commit_valid | output | 1 | Architectural register write |
| commit_tag | output | TAG_W | Tag being retired |
| commit_dest | output | AREG_W | Register written |
| commit_data | output | DATA_W | Value written |
| exc_valid | output | 1 | Exception request |
| exc_pc | output | PC_W | PC of faulting instruction |

## Verification
The hardest case to reach is a mispredict that rewinds the tail across the wrap point. Only there can a wrong wrap bit mistake a full buffer for an empty one. The stimulus fills all six slots and retires five of them, which leaves the head on the last index. It then allocates a branch into slot 0 and flushes it. After that it refills the buffer to exactly full. A second hard case is an exception sitting behind an incomplete older slot, so that the exception request has to wait for an ordinary commit first.

// File: rtl/reorder_ring.sv
module reorder_ring #(
  parameter int DEPTH  = 6,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [AREG_W-1:0] alloc_dest,
  input  logic [PC_W-1:0]   alloc_pc,
  input  logic              alloc_branch,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cmp_valid,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              cmp_exc,
  input  logic              cmp_mispred,
  output logic              wake_valid,
  output logic [TAG_W-1:0]  wake_tag,
  output logic              flush_valid,
  output logic [TAG_W-1:0]  flush_tag,
  output logic              commit_valid,
  output logic [TAG_W-1:0]  commit_tag,
  output logic [AREG_W-1:0] commit_dest,
  output logic [DATA_W-1:0] commit_data,
  output logic              exc_valid,
  output logic [PC_W-1:0]   exc_pc
);
  localparam int SLOTS = 1 << TAG_W;
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  logic [TAG_W-1:0]  hd, tl;
  logic              hw, tw;
  logic [SLOTS-1:0]  vld, done, exc, br, vld_n, kill;
  logic [AREG_W-1:0] dst [SLOTS];
  logic [DATA_W-1:0] dat [SLOTS];
  logic [PC_W-1:0]   pcs [SLOTS];

  function automatic logic [TAG_W-1:0] step_idx(input logic [TAG_W-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  function automatic int age_of(input logic [TAG_W-1:0] i, input logic [TAG_W-1:0] h);
    return (i >= h) ? int'(i) - int'(h) : int'(i) + DEPTH - int'(h);
  endfunction

  logic full, head_rdy, cmp_ok, mispred, alloc_fire, br_wrap;

  assign full         = (hd == tl) && (hw != tw);
  assign head_rdy     = vld[hd] & done[hd];
  assign commit_valid = head_rdy & ~exc[hd];
  assign exc_valid    = head_rdy & exc[hd];
  assign cmp_ok       = cmp_valid & vld[cmp_tag] & ~done[cmp_tag];
  assign mispred      = cmp_ok & cmp_mispred & br[cmp_tag];
  assign alloc_ready  = ~full & ~mispred & ~exc_valid;
  assign alloc_fire   = alloc_valid & alloc_ready;
  assign alloc_tag    = tl;
  assign wake_valid   = cmp_ok;
  assign wake_tag     = cmp_tag;
  assign flush_valid  = mispred;
  assign flush_tag    = cmp_tag;
  assign commit_tag   = hd;
  assign commit_dest  = dst[hd];
  assign commit_data  = dat[hd];
  assign exc_pc       = pcs[hd];
  assign br_wrap      = (cmp_tag >= hd) ? hw : ~hw;

  always_comb begin
    kill = '0;
    for (int i = 0; i < DEPTH; i++)
      kill[i] = age_of(TAG_W'(i), hd) > age_of(cmp_tag, hd);
    vld_n = vld;
    if (alloc_fire)   vld_n[tl] = 1'b1;
    if (commit_valid) vld_n[hd] = 1'b0;
    if (mispred)      vld_n = vld_n & ~kill;
    if (exc_valid)    vld_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd <= '0; tl <= '0; hw <= 1'b0; tw <= 1'b0;
      vld <= '0; done <= '0; exc <= '0; br <= '0;
    end else begin
      vld <= vld_n;
      if (alloc_fire) begin
        done[tl] <= 1'b0;
        exc[tl]  <= 1'b0;
        br[tl]   <= alloc_branch;
        dst[tl]  <= alloc_dest;
        pcs[tl]  <= alloc_pc;
      end
      if (cmp_ok) begin
        done[cmp_tag] <= 1'b1;
        exc[cmp_tag]  <= cmp_exc;
        dat[cmp_tag]  <= cmp_data;
      end
      if (commit_valid) begin
        hd <= step_idx(hd);
        if (hd == LAST) hw <= ~hw;
      end
      if (exc_valid) begin
        tl <= hd; tw <= hw;
      end else if (mispred) begin
        tl <= step_idx(cmp_tag);
        tw <= (cmp_tag == LAST) ? ~br_wrap : br_wrap;
      end else if (alloc_fire) begin
        tl <= step_idx(tl);
        if (tl == LAST) tw <= ~tw;
      end
    end
  end

  int occ;
  assign occ = (hw == tw) ? int'(tl) - int'(hd) : DEPTH - int'(hd) + int'(tl);

  p_occupancy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) == occ);
  p_commit_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> hd == step_idx($past(hd)));
  p_exc_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (vld == '0) && (hd == tl) && (hw == tw));
  p_flush_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> alloc_tag == step_idx($past(cmp_tag)));
  p_flushed_gone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> $countones(vld) == age_of($past(cmp_tag), $past(hd)) + 1
                    - ($past(commit_valid) ? 1 : 0));
endmodule

// File: tb/reorder_ring_tb.sv
module reorder_ring_tb;
  localparam int TAG_W = 3;
  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_branch = 0, alloc_ready;
  logic [4:0] alloc_dest = 0;
  logic [31:0] alloc_pc = 0;
  logic [TAG_W-1:0] alloc_tag;
  logic cmp_valid = 0, cmp_exc = 0, cmp_mispred = 0;
  logic [TAG_W-1:0] cmp_tag = 0;
  logic [31:0] cmp_data = 0;
  logic wake_valid, flush_valid, commit_valid, exc_valid;
  logic [TAG_W-1:0] wake_tag, flush_tag, commit_tag;
  logic [4:0] commit_dest;
  logic [31:0] commit_data, exc_pc;

  reorder_ring u_dut (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit last_rdy;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reset_dut();
    alloc_valid = 0; cmp_valid = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic do_alloc(input logic [4:0] d, input logic [31:0] pc, input bit b,
                          output logic [TAG_W-1:0] tag);
    alloc_valid = 1; alloc_dest = d; alloc_pc = pc; alloc_branch = b;
    #2 tag = alloc_tag; last_rdy = alloc_ready;
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic do_cmp(input logic [TAG_W-1:0] t, input logic [31:0] v,
                        input bit e, input bit m, output bit wk, output bit fl);
    cmp_valid = 1; cmp_tag = t; cmp_data = v; cmp_exc = e; cmp_mispred = m;
    #2 wk = wake_valid && wake_tag == t; fl = flush_valid && flush_tag == t;
    last_rdy = alloc_ready;
    @(negedge clk);
    cmp_valid = 0; cmp_exc = 0; cmp_mispred = 0;
  endtask

  task automatic expect_commit(input string req, input int t, input int d, input int v);
    #2;
    chk(commit_valid && commit_tag == t, req, "commit tag", {commit_valid, commit_tag}, {1'b1, 3'(t)});
    chk(commit_dest == d && commit_data == v, req, "commit dest/data", commit_data, v);
    @(negedge clk);
  endtask

  task automatic t_reset();
    reset_dut(); #2;
    chk(alloc_ready && alloc_tag == 0, "R1", "ready/tag", {alloc_ready, alloc_tag}, 4'b1000);
    chk(!commit_valid && !exc_valid, "R1", "commit/exc idle", {commit_valid, exc_valid}, 0);
    @(negedge clk);
  endtask

  task automatic t_fill();
    logic [TAG_W-1:0] tg; bit wk, fl;
    reset_dut();
    for (int i = 0; i < 6; i++) begin
      do_alloc(5'(i), 32'h0, 0, tg);
      chk(tg == i && last_rdy, "R2", "sequential tag", tg, i);
    end
    #2 chk(!alloc_ready, "R2", "full blocks alloc", alloc_ready, 0);
    do_alloc(5'd9, 32'h0, 0, tg);
    #2 chk(alloc_tag == 0 && !alloc_ready, "R2", "alloc while full ignored", alloc_tag, 0);
    @(negedge clk);
    do_cmp(0, 32'h55, 0, 0, wk, fl);
    expect_commit("R4", 0, 0, 32'h55);
    #2 chk(alloc_ready && alloc_tag == 0, "R9", "tag wraps to 0", alloc_tag, 0);
    @(negedge clk);
  endtask

  task automatic t_ooo();
    logic [TAG_W-1:0] tg; bit wk, fl;
    reset_dut();
    for (int i = 0; i < 3; i++) do_alloc(5'(3 + i), 32'h0, 0, tg);
    do_cmp(2, 32'hA2, 0, 0, wk, fl);
    chk(wk, "R3", "wakeup tag 2", wk, 1);
    #2 chk(!commit_valid, "R4", "younger waits", commit_valid, 0);
    @(negedge clk);
    do_cmp(1, 32'hA1, 0, 0, wk, fl);
    chk(wk, "R3", "wakeup tag 1", wk, 1);
    #2 chk(!commit_valid, "R4", "still waiting on head", commit_valid, 0);
    @(negedge clk);
    do_cmp(0, 32'hA0, 0, 0, wk, fl);
    expect_commit("R4", 0, 3, 32'hA0);
    expect_commit("R4", 1, 4, 32'hA1);
    expect_commit("R4", 2, 5, 32'hA2);
    #2 chk(!commit_valid && alloc_tag == 3, "R4", "drained", alloc_tag, 3);
    @(negedge clk);
  endtask

  task automatic t_exc();
    logic [TAG_W-1:0] tg; bit wk, fl;
    reset_dut();
    for (int i = 0; i < 3; i++) do_alloc(5'(i + 1), 32'h100 + 32'(4 * i), 0, tg);
    do_cmp(1, 32'hB1, 1, 0, wk, fl);
    #2 chk(!exc_valid && !commit_valid, "R5", "exception waits for head", exc_valid, 0);
    @(negedge clk);
    do_cmp(0, 32'hB0, 0, 0, wk, fl);
    expect_commit("R5", 0, 1, 32'hB0);
    #2 chk(exc_valid && !commit_valid, "R5", "exception at head", {exc_valid, commit_valid}, 2'b10);
    chk(exc_pc == 32'h104, "R5", "exception pc", exc_pc, 32'h104);
    @(negedge clk);
    #2 chk(!exc_valid && !commit_valid && alloc_ready && alloc_tag == 1, "R5",
           "emptied after exception", alloc_tag, 1);
    @(negedge clk);
    do_cmp(2, 32'hB2, 0, 0, wk, fl);
    chk(!wk, "R7", "completion after flush ignored", wk, 0);
    #2 chk(!commit_valid, "R7", "no commit of dropped slot", commit_valid, 0);
    @(negedge clk);
  endtask

  task automatic t_mispred();
    logic [TAG_W-1:0] tg; bit wk, fl;
    reset_dut();
    do_alloc(5'd1, 32'h0, 0, tg);
    do_alloc(5'd2, 32'h0, 1, tg);
    do_alloc(5'd3, 32'h0, 0, tg);
    do_alloc(5'd4, 32'h0, 0, tg);
    do_cmp(2, 32'hC2, 0, 0, wk, fl);
    do_cmp(1, 32'hC1, 0, 1, wk, fl);
    chk(fl, "R6", "flush on branch", fl, 1);
    chk(!last_rdy, "R6", "alloc blocked in flush cycle", last_rdy, 0);
    #2 chk(alloc_tag == 2, "R6", "tail after branch", alloc_tag, 2);
    @(negedge clk);
    do_cmp(3, 32'hC3, 0, 0, wk, fl);
    chk(!wk, "R7", "flushed tag ignored", wk, 0);
    do_cmp(0, 32'hC0, 0, 0, wk, fl);
    expect_commit("R6", 0, 1, 32'hC0);
    expect_commit("R6", 1, 2, 32'hC1);
    #2 chk(!commit_valid, "R6", "younger done slot discarded", commit_valid, 0);
    @(negedge clk);
  endtask

  task automatic t_nonbranch();
    logic [TAG_W-1:0] tg; bit wk, fl;
    reset_dut();
    do_alloc(5'd7, 32'h0, 0, tg);
    do_alloc(5'd8, 32'h0, 0, tg);
    do_cmp(0, 32'hD0, 0, 1, wk, fl);
    chk(!fl && last_rdy, "R8", "no flush for non-branch", fl, 0);
    expect_commit("R8", 0, 7, 32'hD0);
    #2 chk(alloc_tag == 2, "R8", "younger slot kept", alloc_tag, 2);
    @(negedge clk);
    do_cmp(1, 32'hD1, 0, 0, wk, fl);
    expect_commit("R8", 1, 8, 32'hD1);
  endtask

  task automatic t_wrap_flush();
    logic [TAG_W-1:0] tg; bit wk, fl;
    reset_dut();
    for (int i = 0; i < 6; i++) do_alloc(5'(i), 32'h0, 0, tg);
    for (int i = 0; i < 5; i++) do_cmp(3'(i), 32'(i), 0, 0, wk, fl);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      do_alloc(5'd20, 32'h0, i == 0, tg);
      chk(tg == i, "R9", "wrapped tag", tg, i);
    end
    do_cmp(0, 32'hE0, 0, 1, wk, fl);
    chk(fl, "R9", "flush across wrap", fl, 1);
    #2 chk(alloc_tag == 1 && alloc_ready, "R9", "tail rewound", alloc_tag, 1);
    @(negedge clk);
    for (int i = 1; i < 5; i++) begin
      do_alloc(5'd21, 32'h0, 0, tg);
      chk(tg == i && last_rdy, "R9", "refill tag", tg, i);
    end
    #2 chk(!alloc_ready, "R9", "full after wrap", alloc_ready, 0);
    @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    @(negedge clk);
    t_reset(); t_fill(); t_ooo(); t_exc(); t_mispred(); t_nonbranch(); t_wrap_flush();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule